// File: doc/BRIEF.md
# Tag CAM With Multi-Hit Error Detection

This block holds a small fully-associative set of address tags. Each entry has a real-address tag and a valid bit. A lookup compares one real address against every valid entry at once. It returns a hit flag, the raw match vector and the binary index of the matching entry. A soft error can flip a stored tag bit so that two entries alias the same address. The block detects this case by counting matches: two or more matches on a lookup-class operation raise a one-cycle multi-hit error. The surrounding cache controller then recovers with an invalidate-all command.

Tags are loaded one entry at a time through a write port, and writing an entry also marks it valid. An invalidate-all command clears every valid bit. A diagnostic line-read operation goes through the same compare path, but it never raises the error. All lookup results are registered and appear one cycle after the lookup is presented.

Top module: `tag_cam_mhit`

## Requirements
- R1: After reset every entry is invalid and all outputs (`hit_o`, `match_o`, `idx_o`, `mhit_o`) are zero, so no lookup can hit until an entry has been written.
- R2: A lookup whose tag matches exactly one valid entry returns, in the next cycle, `hit_o`=1, `match_o` with only that entry's bit set, and `idx_o` equal to the entry number. A lookup that matches no entry returns `hit_o`=0, `match_o`=0 and `idx_o`=0.
- R3: An entry whose valid bit is clear never matches, whatever tag it still stores.
- R4: When two or more valid entries match a lookup-class operation, the next cycle shows `mhit_o`=1, `hit_o`=0 and `idx_o`=0, and `match_o` shows every matching entry.
- R5: The lookup-class operations are the `lk_op` codes 0 to 7 (load, store, flush, invalidate, clean, touch, touch-for-store, zero-line). Each of these codes detects a multi-hit.
- R6: `lk_op` code 8 is the diagnostic line read. It never raises `mhit_o`. It reports `hit_o`, `idx_o` and `match_o` under the same rules as any other lookup.
- R7: `inv_all`=1 clears every valid bit at the clock edge. In the same cycle it takes priority over a tag write.
- R8: A cycle with `lk_valid`=0, or with an `lk_op` code from 9 to 15, produces all-zero outputs in the next cycle.
- R9: A lookup sees the tag contents as they stood before any write or invalidate-all presented in the same cycle.
- R10: `mhit_o` is high for exactly one cycle for each offending lookup. Back-to-back offending lookups give consecutive high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a tag into one entry and set it valid |
| wr_idx | input | 4 | Entry number to write |
| wr_tag | input | 24 | Tag value to write |
| inv_all | input | 1 | Clear every valid bit |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_op | input | 4 | Operation code of the lookup (0-7 lookup class, 8 diagnostic read) |
| lk_tag | input | 24 | Real address to compare |
| hit_o | output | 1 | Exactly one valid entry matched |
| match_o | output | 16 | Per-entry match vector |
| idx_o | output | 4 | Index of the single matching entry, else 0 |
| mhit_o | output | 1 | Multi-hit error pulse |

## Verification
Every lookup result, including the multi-hit pulse, is due exactly one clock edge after the lookup is presented. Writes and invalidate-all commands take effect for lookups presented in the following cycle. The bench drives each cycle's stimulus on the falling edge. It advances a behavioural model of the tag store in step with the drive, samples all four outputs one nanosecond after the next rising edge, and compares them with the model's prediction for the lookup driven in the previous cycle. Same-cycle write-and-lookup cases are arranged on purpose, so that the one-cycle visibility of R9 is compared directly.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD     = 4'd0,
        OP_STORE    = 4'd1,
        OP_FLUSH    = 4'd2,
        OP_INVAL    = 4'd3,
        OP_CLEAN    = 4'd4,
        OP_TOUCH    = 4'd5,
        OP_TOUCH_ST = 4'd6,
        OP_ZERO     = 4'd7,
        OP_DIAG_RD  = 4'd8
    } lk_op_e;

    function automatic logic op_is_lookup_class(input logic [OP_W-1:0] op);
        return op <= OP_ZERO;
    endfunction

    function automatic logic op_is_compare(input logic [OP_W-1:0] op);
        return op <= OP_DIAG_RD;
    endfunction
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                wr_tag,
    input  logic                            inv_all,
    output logic [ENTRIES-1:0][TAG_W-1:0]   tags_o,
    output logic [ENTRIES-1:0]              valid_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inv_all) begin
            st_d.valid = '0;
        end else if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            st_d.valid[wr_idx] = 1'b1;
            st_d.tag[wr_idx]   = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tags_o  = st_q.tag;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/tcam_compare.sv
module tcam_compare #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 24
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [TAG_W-1:0]              lk_tag,
    output logic [ENTRIES-1:0]            match_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g] == lk_tag);
    end
endmodule

// File: rtl/tcam_encode.sv
module tcam_encode #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match_i,
    output logic               any_o,
    output logic               multi_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        any_o   = 1'b0;
        multi_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_i[i]) begin
                if (any_o) multi_o = 1'b1;
                any_o = 1'b1;
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tag_cam_mhit.sv
module tag_cam_mhit
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic               inv_all,
    input  logic               lk_valid,
    input  logic [OP_W-1:0]    lk_op,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               hit_o,
    output logic [ENTRIES-1:0] match_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               mhit_o
);
    logic [ENTRIES-1:0][TAG_W-1:0] tags;
    logic [ENTRIES-1:0]            valid;
    logic [ENTRIES-1:0]            match;
    logic                          any_m, multi_m;
    logic [IDX_W-1:0]              enc_idx;

    tcam_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .inv_all(inv_all),
        .tags_o(tags), .valid_o(valid)
    );

    tcam_compare #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cmp (
        .tags_i(tags), .valid_i(valid), .lk_tag(lk_tag), .match_o(match)
    );

    tcam_encode #(.ENTRIES(ENTRIES)) u_enc (
        .match_i(match), .any_o(any_m), .multi_o(multi_m), .idx_o(enc_idx)
    );

    typedef struct packed {
        logic               hit;
        logic [ENTRIES-1:0] match;
        logic [IDX_W-1:0]   idx;
        logic               mhit;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = '0;
        if (lk_valid && op_is_compare(lk_op)) begin
            res_d.match = match;
            if (multi_m) begin
                res_d.mhit = op_is_lookup_class(lk_op);
            end else if (any_m) begin
                res_d.hit = 1'b1;
                res_d.idx = enc_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit_o   = res_q.hit;
    assign match_o = res_q.match;
    assign idx_o   = res_q.idx;
    assign mhit_o  = res_q.mhit;
endmodule

// File: rtl/tcam_checker.sv
module tcam_checker
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [OP_W-1:0]    lk_op,
    input logic               hit_o,
    input logic [ENTRIES-1:0] match_o,
    input logic [IDX_W-1:0]   idx_o,
    input logic               mhit_o
);
    // R4: an error report never carries a hit or an index
    assert_mhit_clears_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mhit_o |-> (!hit_o && idx_o == '0));

    // R4: an error needs at least two matching entries
    assert_mhit_needs_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mhit_o |-> ($countones(match_o) >= 2));

    // R2: a hit has exactly one match bit, at the reported index
    assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($countones(match_o) == 1 && match_o[idx_o]));

    // R6: diagnostic read never raises the error
    assert_diag_no_mhit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_op == OP_DIAG_RD) |=> !mhit_o);

    // R8: no lookup presented gives quiet outputs
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid || lk_op > OP_DIAG_RD) |=> (!hit_o && !mhit_o && match_o == '0 && idx_o == '0));
endmodule

bind tag_cam_mhit tcam_checker #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_op(lk_op),
    .hit_o(hit_o), .match_o(match_o), .idx_o(idx_o), .mhit_o(mhit_o)
);

// File: tb/tag_cam_mhit_test.sv
module tag_cam_mhit_test;
    localparam int N  = 16;
    localparam int TW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [TW-1:0] wr_tag = '0;
    logic          inv_all = 1'b0;
    logic          lk_valid = 1'b0;
    logic [3:0]    lk_op = '0;
    logic [TW-1:0] lk_tag = '0;
    logic          hit_o;
    logic [N-1:0]  match_o;
    logic [3:0]    idx_o;
    logic          mhit_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tag_cam_mhit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .inv_all(inv_all), .lk_valid(lk_valid), .lk_op(lk_op), .lk_tag(lk_tag),
        .hit_o(hit_o), .match_o(match_o), .idx_o(idx_o), .mhit_o(mhit_o)
    );

    // behavioural model of the tag store
    logic [TW-1:0] m_tag [N];
    bit            m_val [N];

    task automatic check_out(input string req, input bit eh, input logic [N-1:0] em,
                             input logic [3:0] ei, input bit emh);
        n_checks++;
        if (hit_o !== eh || match_o !== em || idx_o !== ei || mhit_o !== emh) begin
            n_fail++;
            $display("FAIL %s: actual hit=%0b match=%h idx=%0d mhit=%0b expected hit=%0b match=%h idx=%0d mhit=%0b",
                     req, hit_o, match_o, idx_o, mhit_o, eh, em, ei, emh);
        end
    endtask

    task automatic cyc(input string req, input bit wv, input int wi, input logic [TW-1:0] wt,
                       input bit inv, input bit lv, input int op, input logic [TW-1:0] lt);
        bit            eh = 0, emh = 0;
        logic [N-1:0]  em = '0;
        logic [3:0]    ei = '0;
        int            cnt = 0;
        @(negedge clk);
        wr_en = wv; wr_idx = 4'(wi); wr_tag = wt; inv_all = inv;
        lk_valid = lv; lk_op = 4'(op); lk_tag = lt;
        if (lv && op <= 8) begin
            for (int i = 0; i < N; i++) begin
                if (m_val[i] && m_tag[i] == lt) begin
                    em[i] = 1'b1;
                    cnt++;
                    ei = 4'(i);
                end
            end
            if (cnt == 1) eh = 1;
            else ei = '0;
            if (cnt >= 2 && op <= 7) emh = 1;
        end
        if (inv) begin
            for (int i = 0; i < N; i++) m_val[i] = 0;
        end else if (wv) begin
            m_val[wi] = 1; m_tag[wi] = wt;
        end
        @(posedge clk);
        #1;
        check_out(req, eh, em, ei, emh);
    endtask

    function automatic logic [TW-1:0] tg(input int i);
        return 24'h100000 + 24'(i * 24'h111);
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_tag[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        check_out("R1 reset outputs", 0, '0, '0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R1 lookup after reset", 0, 0, '0, 0, 1, 0, 24'h0);
        // fill all entries, no lookup presented
        for (int i = 0; i < N; i++) cyc("R8 idle during writes", 1, i, tg(i), 0, 0, 0, '0);
        // single hits across all lookup-class ops
        for (int i = 0; i < N; i++) cyc("R2 single hit", 0, 0, '0, 0, 1, i % 8, tg(i));
        cyc("R2 miss", 0, 0, '0, 0, 1, 0, 24'hABCDEF);
        // same-cycle write and lookup
        cyc("R9 write not yet visible", 1, 3, 24'h777777, 0, 1, 1, 24'h777777);
        cyc("R9 write visible next cycle", 0, 0, '0, 0, 1, 1, 24'h777777);
        cyc("R3 overwritten tag gone", 0, 0, '0, 0, 1, 0, tg(3));
        // alias entry 9 onto entry 5
        cyc("R8 write alias", 1, 9, tg(5), 0, 0, 0, '0);
        for (int op = 0; op < 8; op++) cyc("R5 R10 multi-hit per op", 0, 0, '0, 0, 1, op, tg(5));
        cyc("R10 pulse ends", 0, 0, '0, 0, 1, 0, tg(6));
        cyc("R6 diag on alias", 0, 0, '0, 0, 1, 8, tg(5));
        cyc("R6 diag single hit", 0, 0, '0, 0, 1, 8, tg(12));
        cyc("R4 multi-hit load", 0, 0, '0, 0, 1, 0, tg(5));
        for (int op = 9; op < 16; op++) cyc("R8 reserved op", 0, 0, '0, 0, 1, op, tg(12));
        cyc("R8 lookup not valid", 0, 0, '0, 0, 0, 0, tg(12));
        // invalidate-all with lookup in the same cycle, and priority over write
        cyc("R9 lookup before invalidate", 0, 0, '0, 1, 1, 2, tg(5));
        cyc("R7 cleared after invalidate", 0, 0, '0, 0, 1, 2, tg(5));
        cyc("R7 invalidate beats write", 1, 4, 24'h444444, 1, 0, 0, '0);
        cyc("R7 write dropped", 0, 0, '0, 0, 1, 0, 24'h444444);
        cyc("R3 stale tag misses", 0, 0, '0, 0, 1, 0, tg(10));
        cyc("R2 rewrite entry 15", 1, 15, 24'h00F00F, 0, 0, 0, '0);
        cyc("R2 hit top entry", 0, 0, '0, 0, 1, 7, 24'h00F00F);
        cyc("R3 unwritten zero tag", 0, 0, '0, 0, 1, 3, 24'h000000);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule